// File: doc/BRIEF.md
# Dual-Rail Bipolar Line Decoder with Violation Counting

This block takes a received bipolar line as two rails, one pulsing for positive marks and one for negative marks, and turns it into a single NRZ data bit per symbol. Two zero-substitution codes are supported. In the three-zero code (DS3 mode) the signatures `00V` and `B0V` stand in for three zeros. In the four-zero code (E3 mode) the signatures `000V` and `B00V` stand in for four zeros. Here `V` is a mark with the same polarity as the mark before it, and `B` is an ordinary alternating mark that is part of the signature. Signatures are recognised inside a short window of recent symbols and are turned back into zeros before the data leaves. A pass-through AMI mode turns off substitution decoding.

Line errors are classified differently in each mode and counted in one saturating counter. A single-cycle read strobe copies the counter into a holding register and clears the counter. The rules that decide what counts as an error are selected by the same mode input that selects the substitution code.

Top module: `bipolar_line_decoder`

## Requirements
- R1: In DS3 mode (`e3_mode_i`=0, `ami_mode_i`=0), a symbol is taken on each cycle with `sym_vld_i` high. `rail_p_i` high means a positive mark, `rail_n_i` high means a negative mark, and both low means a zero. A mark with the same polarity as the previous mark is a bipolar violation (BPV); the first mark after reset is never a BPV. A BPV that directly follows a zero completes a signature. That BPV is output as 0, and so is the mark two symbols before it when present (`B0V`). A well-formed signature adds nothing to the counter.
- R2: In E3 mode (`e3_mode_i`=1, `ami_mode_i`=0), a BPV that follows two zeros completes a signature. That BPV is output as 0, and so is the mark three symbols before it when present (`B00V`). A well-formed signature adds nothing to the counter.
- R3: Each accepted symbol appears on `data_o` (1 for a mark, 0 for a zero or a removed signature mark) one cycle after the fourth later symbol is accepted. `data_vld_o` is high for exactly that cycle, and it never rises before four symbols have entered since reset.
- R4: In DS3 mode, the `B` form is due when the number of marks since reset or since the last signature (not counting the `B`) is even, and the zero-led form is due when it is odd. A signature of the wrong form is still removed but adds one to the counter.
- R5: In DS3 mode, a BPV that does not follow a zero is passed as a 1 and adds one to the counter. A run of zeros on the line adds one to the counter when it reaches `EXZ_LEN` zeros (default 3), once per run.
- R6: In E3 mode, a BPV adds one to the counter only when the previous BPV had the same polarity. Runs of zeros of any length add nothing.
- R7: In AMI mode (`ami_mode_i`=1), nothing is substituted and every BPV is passed as a 1 and adds one to the counter. Zero runs add nothing.
- R8: A cycle with `cnt_rd_i` high loads `cnt_o` with the counter value and clears the counter. `cnt_o` changes on no other cycle.
- R9: The counter stops at its all-ones value (0xFFFF for `CNT_W`=16) and does not wrap.
- R10: When a read and a counted event fall in the same cycle, `cnt_o` takes the value from before the event, and the counter restarts at 1.
- R11: After reset, `data_o`, `data_vld_o` and `cnt_o` are 0 and the counter is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_vld_i | input | 1 | A line symbol is present on the rails this cycle |
| rail_p_i | input | 1 | Positive-mark rail |
| rail_n_i | input | 1 | Negative-mark rail |
| e3_mode_i | input | 1 | 0: three-zero code and DS3 error rules; 1: four-zero code and E3 error rules |
| ami_mode_i | input | 1 | 1: no substitution decoding, every BPV counted |
| data_o | output | 1 | Decoded NRZ bit |
| data_vld_o | output | 1 | `data_o` carries a decoded bit this cycle |
| cnt_rd_i | input | 1 | Read strobe: load `cnt_o` and clear the counter |
| cnt_o | output | CNT_W | Counter value captured by the last read |

## Verification
The bench builds the decoder with `CNT_W`=8 and the default `EXZ_LEN`=3. The narrow counter reaches saturation after a few hundred BPVs in AMI mode, so the stop-at-all-ones rule and a read straight after saturation can be tested within the cycle budget. With the default zero-run limit, the excess-zero rule in DS3 is triggered by ordinary short patterns. Those same patterns contain four-zero runs, which must stay uncounted in E3 and AMI modes.

// File: rtl/bld_pkg.sv
`timescale 1ns/1ps
// Package: shared types and constants for the bipolar line decoder.
// Assumes one symbol per accepted cycle; the window depth is fixed by the
// longest signature (four symbols in the four-zero code).
package bld_pkg;

    // One line symbol: is it a mark, and if so is it positive
    typedef struct packed {
        logic mark;
        logic pos;
    } sym_t;

    // Classification of the newest symbol against the window
    typedef struct packed {
        logic bpv;       // mark with same polarity as previous mark
        logic sig;       // completes a substitution signature
        logic bform;     // signature carries a leading B mark
        logic form_bad;  // signature form disagrees with the mark parity
    } cls_t;

    localparam int WIN_DEPTH  = 4;  // symbols held before output
    localparam int B3_B_SLOT  = 1;  // window slot of B in the three-zero code
    localparam int HDB_B_SLOT = 2;  // window slot of B in the four-zero code

    // Map the two rails to a symbol; both rails high reads as a positive mark
    function automatic sym_t rails_to_sym(input logic p, input logic n);
        sym_t s;
        s.mark = p | n;
        s.pos  = p;
        return s;
    endfunction

endpackage

// File: rtl/bld_classify.sv
`timescale 1ns/1ps
// Module: bld_classify
// Pure combinational view of the newest symbol. It decides whether the symbol
// is a bipolar violation and whether, with the marks already in the window, it
// closes a substitution signature. Assumes the caller holds the polarity of
// the last mark, a flag for "any mark seen", and the parity of marks counted
// since the last signature (the B of a signature is already included).
module bld_classify
    import bld_pkg::*;
(
    input  sym_t cur_i,
    input  logic p1_mark_i,   // symbol just before cur
    input  logic p2_mark_i,   // two before
    input  logic p3_mark_i,   // three before
    input  logic seen_i,
    input  logic last_pos_i,
    input  logic parity_i,
    input  logic e3_i,
    input  logic ami_i,
    output cls_t cls_o
);

    logic zero_lead;

    // Classify the incoming symbol
    always_comb begin
        cls_o.bpv   = cur_i.mark & seen_i & (cur_i.pos == last_pos_i);
        zero_lead   = e3_i ? (~p1_mark_i & ~p2_mark_i) : ~p1_mark_i;
        cls_o.sig   = cls_o.bpv & ~ami_i & zero_lead;
        cls_o.bform = e3_i ? p3_mark_i : p2_mark_i;
        // Parity including B must be odd for either form to be right: an
        // even count before B asks for B, an odd count asks for the zero form.
        cls_o.form_bad = cls_o.sig & ~parity_i;
    end

endmodule

// File: rtl/bld_viol_rules.sv
`timescale 1ns/1ps
// Module: bld_viol_rules
// Applies the mode-dependent counting rules and emits one increment pulse per
// counted event. Tracks the raw zero-run length and the polarity of the last
// BPV. Assumes at most one event per accepted symbol, which holds because
// zero-run events happen on zeros and BPV events happen on marks.
module bld_viol_rules
    import bld_pkg::*;
#(
    parameter int EXZ_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_i,
    input  sym_t cur_i,
    input  logic bpv_i,
    input  logic sig_i,
    input  logic form_bad_i,
    input  logic e3_i,
    input  logic ami_i,
    output logic inc_o
);

    localparam int ZR_W = $clog2(EXZ_LEN + 1);

    logic [ZR_W-1:0] zrun;
    logic            vseen;
    logic            vpos;
    logic            zhit;
    logic            event_q;

    // Decide whether the current symbol is a counted event
    always_comb begin
        zhit = ~cur_i.mark & (zrun == ZR_W'(EXZ_LEN - 1));
        if (ami_i)
            event_q = bpv_i;
        else if (e3_i)
            event_q = bpv_i & vseen & (cur_i.pos == vpos);
        else
            event_q = (bpv_i & ~sig_i) | form_bad_i | zhit;
        inc_o = vld_i & event_q;
    end

    // Track raw zero-run length, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n)
            zrun <= '0;
        else if (vld_i) begin
            if (cur_i.mark)
                zrun <= '0;
            else if (zrun != ZR_W'(EXZ_LEN))
                zrun <= zrun + 1'b1;
        end
    end

    // Remember polarity of the most recent BPV
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vseen <= 1'b0;
            vpos  <= 1'b0;
        end else if (vld_i && bpv_i) begin
            vseen <= 1'b1;
            vpos  <= cur_i.pos;
        end
    end

endmodule

// File: rtl/bld_err_counter.sv
`timescale 1ns/1ps
// Module: bld_err_counter
// Saturating event counter with clear-on-read. A read copies the count to the
// holding register; an event in the same cycle becomes the new count of one.
// Assumes at most one increment per cycle.
module bld_err_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             rd_i,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] rd_data_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count events, clear on read, stop at all ones
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q_o <= '0;
        else if (rd_i)
            cnt_q_o <= inc_i ? CNT_W'(1) : '0;
        else if (inc_i && cnt_q_o != CNT_MAX)
            cnt_q_o <= cnt_q_o + 1'b1;
    end

    // Capture the count for the reader
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data_o <= '0;
        else if (rd_i)
            rd_data_o <= cnt_q_o;
    end

endmodule

// File: rtl/bipolar_line_decoder.sv
`timescale 1ns/1ps
// Module: bipolar_line_decoder
// Dual-rail bipolar to NRZ decoder for the three-zero and four-zero
// substitution codes, with an AMI pass-through mode and a clear-on-read
// violation counter. Symbols pass through a window of WIN_DEPTH slots so that
// a signature's leading B mark can be removed before it leaves. Assumes the
// mode inputs are static while symbols flow.
module bipolar_line_decoder #(
    parameter int CNT_W   = 16,
    parameter int EXZ_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_vld_i,
    input  logic             rail_p_i,
    input  logic             rail_n_i,
    input  logic             e3_mode_i,
    input  logic             ami_mode_i,
    output logic             data_o,
    output logic             data_vld_o,
    input  logic             cnt_rd_i,
    output logic [CNT_W-1:0] cnt_o
);

    import bld_pkg::*;

    localparam int FILL_W = $clog2(WIN_DEPTH + 1);

    sym_t                 cur;
    cls_t                 cls;
    logic [WIN_DEPTH-1:0] win_mark;   // [0] newest stored symbol
    logic [WIN_DEPTH-1:0] clr_slot;
    logic                 seen;
    logic                 last_pos;
    logic                 parity;
    logic [FILL_W-1:0]    fill;
    logic                 err_inc;
    logic [CNT_W-1:0]     err_cnt;

    assign cur = rails_to_sym(rail_p_i, rail_n_i);

    bld_classify u_cls (
        .cur_i      (cur),
        .p1_mark_i  (win_mark[0]),
        .p2_mark_i  (win_mark[1]),
        .p3_mark_i  (win_mark[2]),
        .seen_i     (seen),
        .last_pos_i (last_pos),
        .parity_i   (parity),
        .e3_i       (e3_mode_i),
        .ami_i      (ami_mode_i),
        .cls_o      (cls)
    );

    // Per-slot clear: the B mark of a completed signature is removed
    for (genvar k = 0; k < WIN_DEPTH; k++) begin : g_clr
        assign clr_slot[k] = cls.sig & cls.bform &
                             (k == (e3_mode_i ? HDB_B_SLOT : B3_B_SLOT));
    end

    // Newest slot takes the input, with the V mark removed on a signature
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_mark[0] <= 1'b0;
        else if (sym_vld_i)
            win_mark[0] <= cur.mark & ~cls.sig;
    end

    // Older slots shift forward, dropping a B mark where flagged
    for (genvar k = 1; k < WIN_DEPTH; k++) begin : g_win
        always_ff @(posedge clk) begin
            if (!rst_n)
                win_mark[k] <= 1'b0;
            else if (sym_vld_i)
                win_mark[k] <= win_mark[k-1] & ~clr_slot[k-1];
        end
    end

    // Count symbols in the window up to its depth
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill <= '0;
        else if (sym_vld_i && fill != FILL_W'(WIN_DEPTH))
            fill <= fill + 1'b1;
    end

    // Emit the oldest symbol once the window is full
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o     <= 1'b0;
            data_vld_o <= 1'b0;
        end else begin
            data_vld_o <= sym_vld_i & (fill == FILL_W'(WIN_DEPTH));
            if (sym_vld_i)
                data_o <= win_mark[WIN_DEPTH-1] & ~clr_slot[WIN_DEPTH-1];
        end
    end

    // Track last mark polarity and mark parity since the last signature
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen     <= 1'b0;
            last_pos <= 1'b0;
            parity   <= 1'b0;
        end else if (sym_vld_i) begin
            if (cur.mark) begin
                seen     <= 1'b1;
                last_pos <= cur.pos;
            end
            if (cls.sig)
                parity <= 1'b0;
            else if (cur.mark)
                parity <= ~parity;
        end
    end

    bld_viol_rules #(.EXZ_LEN(EXZ_LEN)) u_viol (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld_i      (sym_vld_i),
        .cur_i      (cur),
        .bpv_i      (cls.bpv),
        .sig_i      (cls.sig),
        .form_bad_i (cls.form_bad),
        .e3_i       (e3_mode_i),
        .ami_i      (ami_mode_i),
        .inc_o      (err_inc)
    );

    bld_err_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (err_inc),
        .rd_i      (cnt_rd_i),
        .cnt_q_o   (err_cnt),
        .rd_data_o (cnt_o)
    );

endmodule

// File: rtl/bld_decoder_chk.sv
`timescale 1ns/1ps
// Module: bld_decoder_chk
// Property checker bound into the decoder top. Observes ports plus the
// internal increment pulse and live count.
module bld_decoder_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sym_vld_i,
    input logic             rail_p_i,
    input logic             rail_n_i,
    input logic             e3_mode_i,
    input logic             ami_mode_i,
    input logic             data_vld_o,
    input logic             cnt_rd_i,
    input logic [CNT_W-1:0] cnt_o,
    input logic [CNT_W-1:0] err_cnt,
    input logic             err_inc
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R3
    vld_follows_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_vld_o |-> $past(sym_vld_i));

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_rd_i |=> $stable(cnt_o));

    // R8
    rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rd_i |=> (err_cnt <= CNT_W'(1)));

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt == CNT_MAX && !cnt_rd_i) |=> (err_cnt == CNT_MAX));

    // R6
    e3_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e3_mode_i && sym_vld_i && !rail_p_i && !rail_n_i) |-> !err_inc);

    // R7
    ami_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ami_mode_i && sym_vld_i && !rail_p_i && !rail_n_i) |-> !err_inc);

endmodule

bind bipolar_line_decoder bld_decoder_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_vld_i  (sym_vld_i),
    .rail_p_i   (rail_p_i),
    .rail_n_i   (rail_n_i),
    .e3_mode_i  (e3_mode_i),
    .ami_mode_i (ami_mode_i),
    .data_vld_o (data_vld_o),
    .cnt_rd_i   (cnt_rd_i),
    .cnt_o      (cnt_o),
    .err_cnt    (err_cnt),
    .err_inc    (err_inc)
);

// File: tb/test_bipolar_line_decoder.sv
`timescale 1ns/1ps
// Bench: table of line patterns with expected decoded bits and counts, then
// directed tests for latency, saturation, read/event collision and reset.
module test_bipolar_line_decoder;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sym_vld_i = 1'b0;
    logic             rail_p_i = 1'b0;
    logic             rail_n_i = 1'b0;
    logic             e3_mode_i = 1'b0;
    logic             ami_mode_i = 1'b0;
    logic             cnt_rd_i = 1'b0;
    logic             data_o;
    logic             data_vld_o;
    logic [CNT_W-1:0] cnt_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bipolar_line_decoder #(.CNT_W(CNT_W), .EXZ_LEN(3)) i_bipolar_line_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .sym_vld_i  (sym_vld_i),
        .rail_p_i   (rail_p_i),
        .rail_n_i   (rail_n_i),
        .e3_mode_i  (e3_mode_i),
        .ami_mode_i (ami_mode_i),
        .data_o     (data_o),
        .data_vld_o (data_vld_o),
        .cnt_rd_i   (cnt_rd_i),
        .cnt_o      (cnt_o)
    );

    always #10 clk = ~clk;

    // Vector: mode, 16-symbol line ("+", "-", "0"), first 12 decoded bits, count
    typedef struct packed {
        logic         e3;
        logic         ami;
        logic [127:0] line;
        logic [95:0]  expd;
        logic [7:0]   cnt;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, "+-+0+-00-+-+-+-+", "110001000111", 8'd0},  // R1 both forms
        '{1'b0, 1'b0, "+-00-+-0-+-+-+-+", "110001000111", 8'd2},  // R4 wrong forms
        '{1'b0, 1'b0, "++-0000+-+-+-+-+", "111000011111", 8'd2},  // R5 BPV and zeros
        '{1'b1, 1'b0, "+-+00+-000-+-+-+", "110000100001", 8'd0},  // R2 both forms
        '{1'b1, 1'b0, "++--++-++-0000+-", "111111111100", 8'd1},  // R6 LCV pair
        '{1'b0, 1'b1, "+-+0+-0000+-+-+-", "111011000011", 8'd1},  // R7 AMI, DS3
        '{1'b1, 1'b1, "+++-000-+-+-+-+-", "111100011111", 8'd3}   // R7 AMI, E3
    };

    // Output capture ring, written only here
    int   cap_total = 0;
    logic cap_bits [64];

    // Record every decoded bit
    always @(negedge clk) begin
        if (rst_n && data_vld_o) begin
            cap_bits[cap_total % 64] = data_o;
            cap_total = cap_total + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [7:0] c, input logic rd);
        @(negedge clk);
        sym_vld_i = v;
        rail_p_i  = v && (c == "+");
        rail_n_i  = v && (c == "-");
        cnt_rd_i  = rd;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sym_vld_i = 1'b0; rail_p_i = 1'b0; rail_n_i = 1'b0; cnt_rd_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic read_cnt();
        step(1'b0, "0", 1'b1);
        step(1'b0, "0", 1'b0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        logic [11:0] act_bits;
        logic [11:0] exp_bits;

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            e3_mode_i  = VECS[v].e3;
            ami_mode_i = VECS[v].ami;
            do_reset();
            base = cap_total;
            for (int i = 0; i < 16; i++)
                step(1'b1, VECS[v].line[8*(15-i) +: 8], 1'b0);
            step(1'b0, "0", 1'b0);
            read_cnt();
            for (int i = 0; i < 12; i++) begin
                act_bits[11-i] = cap_bits[(base + i) % 64];
                exp_bits[11-i] = (VECS[v].expd[8*(11-i) +: 8] == "1");
            end
            chk($sformatf("R3 vec%0d output count", v), cap_total - base, 12);
            chk($sformatf("R1/R2/R7 vec%0d decoded bits", v), act_bits, exp_bits);
            chk($sformatf("R4/R5/R6 vec%0d error count", v), cnt_o, VECS[v].cnt);
        end

        // R11: reset after a dirty run clears the outputs
        do_reset();
        chk("R11 cnt_o after reset", cnt_o, 0);
        chk("R11 data_vld_o after reset", data_vld_o, 0);
        chk("R11 data_o after reset", data_o, 0);

        // R3: no output before the window fills, then first symbol appears
        e3_mode_i = 1'b0; ami_mode_i = 1'b0;
        step(1'b1, "+", 1'b0);
        step(1'b1, "-", 1'b0);
        step(1'b1, "+", 1'b0);
        step(1'b1, "-", 1'b0);
        step(1'b0, "0", 1'b0);
        chk("R3 no valid after four symbols", data_vld_o, 0);
        step(1'b1, "+", 1'b0);
        step(1'b0, "0", 1'b0);
        chk("R3 valid after fifth symbol", data_vld_o, 1);
        chk("R3 first decoded bit", data_o, 1);
        step(1'b0, "0", 1'b0);
        chk("R3 valid drops with no symbol", data_vld_o, 0);

        // R9: saturation with the narrow counter
        ami_mode_i = 1'b1;
        do_reset();
        for (int i = 0; i < 300; i++)
            step(1'b1, "+", 1'b0);
        step(1'b0, "0", 1'b0);
        read_cnt();
        chk("R9 count stops at all ones", cnt_o, 8'hFF);
        read_cnt();
        chk("R8 count cleared by read", cnt_o, 0);

        // R10: read in the same cycle as an event
        do_reset();
        step(1'b1, "+", 1'b0);
        step(1'b1, "+", 1'b0);
        step(1'b1, "+", 1'b0);
        step(1'b1, "+", 1'b1);
        step(1'b0, "0", 1'b0);
        chk("R10 read returns value before event", cnt_o, 2);
        read_cnt();
        chk("R10 colliding event kept as one", cnt_o, 1);

        // R8: cnt_o holds without a read while events accumulate
        step(1'b1, "+", 1'b0);
        step(1'b1, "+", 1'b0);
        step(1'b1, "+", 1'b0);
        step(1'b0, "0", 1'b0);
        chk("R8 cnt_o holds without read", cnt_o, 1);
        read_cnt();
        chk("R8 read returns accumulated count", cnt_o, 3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule